// File: doc/BRIEF.md
# Watchdog Timer with Selectable Count Rate

This block is a software-controlled watchdog for a small 8-bit microcontroller. Its count clock can come from two places. One is a five-stage divide-by-two prescaler fed by a base tick that is derived from the main clock. The other is a set of four ticks that are already divided down from the sub-clock. A 3-bit select field picks one of eight rates. An 8-bit up-counter advances once for each selected tick while the watchdog is running. When the counter wraps from 0xFF to 0x00, the block issues a one-cycle request. Software chooses whether that request is a reset request or a non-maskable interrupt request.

Software reaches the block through a minimal register bus. There is one write strobe and a 1-bit address. Address 0 is the control register and address 1 is the read-only counter. Read data is combinational from the address. Software services the watchdog by writing the control register with the clear bit set. That write zeroes both the counter and the prescaler, so the next timeout is a full period away. Every tick input is a single-cycle enable pulse in the system clock domain.

Top module: `wdog_top`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0x00, and both request outputs are low.
- R2: The control register at address 0 stores bit 7 (run), bit 6 (action: 0 = reset request, 1 = NMI request) and bits 2:0 (count select). Bits 5:3 always read 0. A write to address 1 changes nothing.
- R3: Writing the control register with bit 7 = 0 clears the counter. While stopped, the counter stays at 0 whatever the ticks do.
- R4: A control write with bit 3 = 1 clears the counter and the prescaler at that write. A write with bit 3 = 0 and bit 7 = 1 leaves the count unchanged.
- R5: Select codes 0, 1, 2 and 3 count one tick per 4, 8, 16 and 32 base ticks. The count is taken from the most recent prescaler clear, so the first count comes on the 4th, 8th, 16th or 32nd base tick.
- R6: Select codes 4, 5, 6 and 7 count pulses of sub_tick_i bits 0, 1, 2 and 3 respectively. The other sub ticks and the base tick have no effect.
- R7: While running, each selected tick raises the counter by one, and the new value is readable in the next cycle.
- R8: With the action bit at 0, the wrap from 0xFF to 0x00 raises rst_req_o for exactly one cycle: the cycle in which the counter first reads 0x00. Counting continues after the wrap.
- R9: With the action bit at 1, the wrap raises nmi_req_o for one cycle instead, and rst_req_o stays low. The two requests are never high together.
- R10: The prescaler is held cleared while the watchdog is stopped. After a restart, the first prescaled count needs the full divide ratio of base ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 counter |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| base_tick_i | input | 1 | Main-clock-derived base tick pulse feeding the prescaler |
| sub_tick_i | input | 4 | Sub-clock-derived tick pulses for select codes 4 to 7 |
| rst_req_o | output | 1 | One-cycle hardware reset request on overflow |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request on overflow |

## Verification
The hardest case to reach from the ports is an overflow at a prescaled rate. The counter needs 256 selected ticks, and each of those needs up to 32 base ticks that no stop or clear write has interrupted. The directed part reaches overflow in both action modes by driving a sub-clock tap directly. The random part then holds the base tick dense and makes clear writes rare, so wraps also happen at the prescaler taps while the bench checks the prescaler phase against its own count of base ticks since the last clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int BIT_RUN  = 7;
    localparam int BIT_ACT  = 6;
    localparam int BIT_CLR  = 3;
    // bits that hold state in the control register: run, action, select
    localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hC7;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CNT  = 1'b1;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              rst_req;
        logic              nmi_req;
    } wdog_state_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int STAGES = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              base_i,
    output logic [STAGES-1:0] tap_o
);
    logic [STAGES-1:0] div_d, div_q;
    logic [STAGES:0]   carry;

    assign carry[0] = base_i;

    // each stage passes a pulse on every second pulse it receives
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign carry[g+1] = carry[g] & div_q[g];
        assign tap_o[g]   = carry[g+1];
    end

    always_comb begin
        div_d = div_q ^ carry[STAGES-1:0];
        if (clr_i) div_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    // R10: a clear leaves every stage at zero
    p_prescale_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (div_q == '0));
endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
    parameter int N_PRE = 4,
    parameter int N_SUB = 4,
    parameter int SEL_W = 3
) (
    input  logic [N_PRE-1:0] pre_i,
    input  logic [N_SUB-1:0] sub_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int N_ALL = N_PRE + N_SUB;
    logic [N_ALL-1:0] all_taps;

    assign all_taps = {sub_i, pre_i};

    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < N_ALL; i++) begin
            if (sel_i == SEL_W'(i)) tick_o = all_taps[i];
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = (cnt_q == CNT_MAX);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clr_i) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
    p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !clr_i) |=> $stable(cnt_q));
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PRE_STAGES = 5,
    parameter int N_SUB      = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              base_tick_i,
    input  logic [N_SUB-1:0]  sub_tick_i,
    output logic              rst_req_o,
    output logic              nmi_req_o
);
    // the first prescaler stage (divide by 2) is not selectable
    localparam int N_PRE = PRE_STAGES - 1;

    wdog_state_t st_d, st_q;
    logic        ctrl_wr, wr_clear, hold_clear;
    logic        running;
    logic [PRE_STAGES-1:0] taps;
    logic        sel_tick, wrap;
    logic [CNT_W-1:0] cnt;

    assign running    = st_q.ctrl[BIT_RUN];
    assign ctrl_wr    = wr_en_i && (addr_i == ADDR_CTRL);
    assign wr_clear   = ctrl_wr && (!wdata_i[BIT_RUN] || wdata_i[BIT_CLR]);
    assign hold_clear = wr_clear || !running;

    wdog_prescaler #(.STAGES(PRE_STAGES)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (hold_clear),
        .base_i (base_tick_i),
        .tap_o  (taps)
    );

    wdog_tick_sel #(.N_PRE(N_PRE), .N_SUB(N_SUB), .SEL_W(SEL_W)) u_sel (
        .pre_i  (taps[PRE_STAGES-1:1]),
        .sub_i  (sub_tick_i),
        .sel_i  (st_q.ctrl[SEL_W-1:0]),
        .tick_o (sel_tick)
    );

    wdog_counter #(.W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (hold_clear),
        .step_i (sel_tick),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = wrap && !st_q.ctrl[BIT_ACT];
        st_d.nmi_req = wrap &&  st_q.ctrl[BIT_ACT];
        if (ctrl_wr) st_d.ctrl = wdata_i & CTRL_KEEP;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        if (addr_i == ADDR_CNT) rdata_o = DATA_W'(cnt);
        else                    rdata_o = st_q.ctrl;
    end

    assign rst_req_o = st_q.rst_req;
    assign nmi_req_o = st_q.nmi_req;

    p_stop_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running |=> (cnt == '0));
    p_clear_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && wdata_i[BIT_CLR]) |=> (cnt == '0));
    p_rst_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);
    p_wrap_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_req_o || nmi_req_o) |-> (cnt == '0));
    p_req_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rst_req_o && nmi_req_o));
endmodule

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       base_tick = 1'b0;
    logic [3:0] sub_tick = 4'h0;
    logic       rst_req, nmi_req;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;
    int nmi_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .base_tick_i(base_tick),
        .sub_tick_i(sub_tick), .rst_req_o(rst_req), .nmi_req_o(nmi_req)
    );

    // behavioural reference
    bit m_run, m_act;
    int m_sel, m_cnt, m_base_seen;
    bit m_rst_req, m_nmi_req;

    always @(posedge clk) begin
        bit clr, tk, wrapped;
        wrapped = 0;
        if (!rst_n) begin
            m_run = 0; m_act = 0; m_sel = 0; m_cnt = 0; m_base_seen = 0;
        end else begin
            clr = (wr_en && addr == 1'b0 && (!wdata[7] || wdata[3])) || !m_run;
            if (clr) begin
                m_cnt = 0; m_base_seen = 0;
            end else begin
                if (m_sel < 4) tk = base_tick && (((m_base_seen + 1) % (4 << m_sel)) == 0);
                else           tk = sub_tick[m_sel - 4];
                if (base_tick) m_base_seen = (m_base_seen + 1) % 32;
                if (tk) begin
                    if (m_cnt == 255) wrapped = 1;
                    m_cnt = (m_cnt + 1) % 256;
                end
            end
            if (wr_en && addr == 1'b0) begin
                m_run = wdata[7]; m_act = wdata[6]; m_sel = int'(wdata[2:0]);
            end
        end
        m_rst_req = wrapped && !m_act;
        m_nmi_req = wrapped && m_act;
    end

    function automatic logic [7:0] model_read(logic a);
        if (a) return 8'(m_cnt);
        return {m_run, m_act, 3'b000, 3'(m_sel)};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check(rdata == model_read(addr), addr ? "R7 count" : "R2 ctrl",
                  int'(rdata), int'(model_read(addr)));
            check(rst_req == m_rst_req, "R8 rst_req", int'(rst_req), int'(m_rst_req));
            check(nmi_req == m_nmi_req, "R9 nmi_req", int'(nmi_req), int'(m_nmi_req));
            if (rst_req) rst_seen++;
            if (nmi_req) nmi_seen++;
        end
    end

    task automatic wr_ctrl(logic [7:0] v, logic a = 1'b0);
        wr_en = 1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
    endtask

    task automatic base_pulses(int n);
        for (int i = 0; i < n; i++) begin
            base_tick = 1; @(negedge clk);
            base_tick = 0; @(negedge clk);
        end
    endtask

    task automatic sub_pulses(logic [3:0] v, int n);
        for (int i = 0; i < n; i++) begin
            sub_tick = v; @(negedge clk);
            sub_tick = 0; @(negedge clk);
        end
    endtask

    task automatic read_expect(logic a, logic [7:0] exp, string tag);
        addr = a; #1;
        check(rdata == exp, tag, int'(rdata), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        read_expect(1'b0, 8'h00, "R1 ctrl after reset");
        read_expect(1'b1, 8'h00, "R1 count after reset");
        check(!rst_req && !nmi_req, "R1 requests low", int'({rst_req, nmi_req}), 0);

        // R5: divide by 4, then clear + divide by 8
        wr_ctrl(8'h80);
        base_pulses(3);
        read_expect(1'b1, 8'h00, "R5 /4 before 4th base tick");
        base_pulses(1);
        read_expect(1'b1, 8'h01, "R5 /4 first count");
        base_pulses(8);
        read_expect(1'b1, 8'h03, "R5 /4 three counts");
        wr_ctrl(8'h89);
        read_expect(1'b1, 8'h00, "R4 clear write zeroes count");
        base_pulses(7);
        read_expect(1'b1, 8'h00, "R5 /8 before 8th tick (R4 prescaler cleared)");
        base_pulses(1);
        read_expect(1'b1, 8'h01, "R5 /8 first count");

        // R10: stop clears the prescaler phase
        wr_ctrl(8'h8A);
        base_pulses(10);
        wr_ctrl(8'h02);
        wr_ctrl(8'h82);
        base_pulses(15);
        read_expect(1'b1, 8'h00, "R10 restart needs full /16");
        base_pulses(1);
        read_expect(1'b1, 8'h01, "R10 first /16 count after restart");

        // R6: sub tap 1 only
        wr_ctrl(8'h8D);
        sub_pulses(4'b0010, 3);
        sub_pulses(4'b1101, 2);
        base_pulses(40);
        read_expect(1'b1, 8'h03, "R6 only sub tick 1 counted");
        wr_ctrl(8'h85);
        read_expect(1'b1, 8'h03, "R4 bit3=0 write keeps count");
        wr_ctrl(8'h55, 1'b1);
        read_expect(1'b1, 8'h03, "R2 write to counter address ignored");
        read_expect(1'b0, 8'h85, "R2 ctrl unchanged by counter write");

        // R3: stop
        wr_ctrl(8'h05);
        read_expect(1'b1, 8'h00, "R3 stop clears count");
        sub_pulses(4'b0010, 3);
        read_expect(1'b1, 8'h00, "R3 stopped count stays 0");
        read_expect(1'b0, 8'h05, "R3 ctrl reads stopped");

        // R8: reset-request overflow
        wr_ctrl(8'h8C);
        sub_pulses(4'b0001, 255);
        read_expect(1'b1, 8'hFF, "R8 count at 0xFF");
        check(rst_seen == 0, "R8 no request before wrap", rst_seen, 0);
        sub_pulses(4'b0001, 1);
        read_expect(1'b1, 8'h00, "R8 wrapped to 0");
        check(rst_seen == 1, "R8 one reset request", rst_seen, 1);
        check(nmi_seen == 0, "R8 no nmi in reset mode", nmi_seen, 0);
        sub_pulses(4'b0001, 2);
        read_expect(1'b1, 8'h02, "R8 counting continues");

        // R9: NMI overflow
        wr_ctrl(8'hCC);
        sub_pulses(4'b0001, 256);
        check(nmi_seen == 1, "R9 one nmi request", nmi_seen, 1);
        check(rst_seen == 1, "R9 no extra reset request", rst_seen, 1);

        // R2: reserved bits and write-only clear bit
        wr_ctrl(8'hFF);
        read_expect(1'b0, 8'hC7, "R2 readback masks bits 5:3");
        wr_ctrl(8'h37);
        read_expect(1'b0, 8'h07, "R2 readback stopped");

        // random phase, model compared every cycle
        wr_ctrl(8'h80);
        for (int i = 0; i < 60000; i++) begin
            base_tick = ($urandom % 8) != 0;
            sub_tick  = 4'($urandom) & 4'($urandom) & 4'($urandom);
            addr      = 1'($urandom);
            wr_en     = ($urandom % 3000) == 0;
            wdata     = {1'b1, 1'($urandom), 2'($urandom), 1'(($urandom % 4) == 0), 3'($urandom)};
            if (($urandom % 20) == 0) wdata[7] = 1'b0;
            @(negedge clk);
        end
        wr_en = 0; base_tick = 0; sub_tick = 0;
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule